// File: doc/BRIEF.md
# Triggered Multi-Frame Stream Capture

This block sits on a free-running sample stream that delivers four complex samples per clock. Each sample is 16 bits of real part and 16 bits of imaginary part, so one beat is 128 bits wide. While idle, the block discards the stream. A trigger opens a capture window, and from that moment the block forwards the stream on an AXI4-Stream master. It marks the end of every 512-sample frame with TLAST and stops after the requested number of frames.

The window starts on the trigger itself, not on an upstream frame edge. Each emitted frame can therefore hold samples from two upstream frames, and a window of N frames touches N+1 upstream frame regions. The downstream DMA gets frames of a fixed length and can reassemble the data as frame size by frame count by trigger count.

The output does not stall the source. A beat that is offered while the sink is not ready is dropped, and the loss is recorded in a sticky flag. A busy level and a one-cycle done pulse report the progress of the window.

Top module: `trig_burst_capture`

## Requirements
- R1: A high `trig_i` while `busy_o` is low starts a window, and `busy_o` is high from the next cycle until the window ends.
- R2: While busy, `m_tvalid` equals `in_valid` and `m_tdata` equals `in_data` bit for bit, with lane k in bits [32k+31:32k]. While idle, `m_tvalid` is low.
- R3: A frame is 128 accepted beats (`m_tvalid` and `m_tready` both high). `m_tlast` is high on the 128th accepted beat of every frame, counted from the first accepted beat of the window.
- R4: A window ends after nframes×128 accepted beats. `done_o` is high for exactly the one cycle after the last beat, and `busy_o` is already low in that cycle.
- R5: `nframes_i` is sampled only in the cycle the trigger is taken. Later changes do not alter the length of the running window.
- R6: An `nframes_i` value of 0 gives a window of one frame.
- R7: A trigger that arrives while `busy_o` is high is ignored and does not restart or lengthen the window.
- R8: When busy, `in_valid` high and `m_tready` low, that beat is dropped, the counters hold and `ovf_o` rises on the next cycle. `ovf_o` stays high until the next trigger is taken, which clears it.
- R9: Cycles with `in_valid` low do not advance the beat or frame position.
- R10: Windows of up to 1024 frames (131072 beats) complete with correct TLAST placement and length.
- R11: After reset, `busy_o`, `done_o`, `ovf_o` and `m_tvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Capture trigger |
| nframes_i | input | 11 | Frames per window (0 means 1) |
| in_valid | input | 1 | Upstream beat valid |
| in_data | input | 128 | Four packed complex samples |
| m_tdata | output | 128 | Stream data |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready |
| m_tlast | output | 1 | Last beat of a frame |
| busy_o | output | 1 | Window in progress |
| done_o | output | 1 | One-cycle end-of-window pulse |
| ovf_o | output | 1 | Sticky dropped-beat flag |

## Verification
The bench triggers at an arbitrary point of the upstream frame count and checks that TLAST follows the window and not the upstream frames. A design that aligned to upstream frames would emit a short first frame. It opens gaps in valid and withholds ready so that the counters must hold. A design that advanced on offered beats rather than accepted ones would place TLAST early and end the window short. It sends triggers and a new frame count during a window, where a restart or a late sample of the count would change the window length. It also covers a zero count and the largest count, where a wrong limit would give no frames or a runaway window. In the drop case it checks that the overflow flag survives the end of the window and clears only on the next trigger.

// File: rtl/cap_pkg.sv
package cap_pkg;
   typedef enum logic {
      CAP_IDLE = 1'b0,
      CAP_RUN  = 1'b1
   } cap_state_e;

   function automatic int unsigned cap_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/cap_beat_ctr.sv
module cap_beat_ctr #(
   parameter int unsigned BEATS = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic last_o
);
   localparam int unsigned BW = cap_pkg::cap_bits(BEATS);
   localparam logic [BW-1:0] LAST_B = BW'(BEATS - 1);

   logic [BW-1:0] cnt_q;

   assign last_o = (cnt_q == LAST_B);

   generate
      if ((BEATS & (BEATS - 1)) == 0) begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n || clr) cnt_q <= '0;
            else if (adv)      cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (!rst_n || clr)      cnt_q <= '0;
            else if (adv && last_o) cnt_q <= '0;
            else if (adv)           cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/cap_frame_ctr.sv
module cap_frame_ctr #(
   parameter int unsigned CW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] nframes_i,
   input  logic          adv,
   output logic          final_o
);
   logic [CW-1:0] lim_q;
   logic [CW-1:0] cnt_q;

   assign final_o = (cnt_q == lim_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lim_q <= '0;
         cnt_q <= '0;
      end else if (load) begin
         lim_q <= (nframes_i == '0) ? '0 : nframes_i - 1'b1;
         cnt_q <= '0;
      end else if (adv && !final_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic finish,
   input  logic drop,
   output logic busy_o,
   output logic done_o,
   output logic ovf_o
);
   import cap_pkg::*;

   cap_state_e st_q;

   assign busy_o = (st_q == CAP_RUN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= CAP_IDLE;
         done_o <= 1'b0;
         ovf_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (st_q)
            CAP_IDLE: if (start) begin
               st_q  <= CAP_RUN;
               ovf_o <= 1'b0;
            end
            CAP_RUN: begin
               if (drop) ovf_o <= 1'b1;
               if (finish) begin
                  st_q   <= CAP_IDLE;
                  done_o <= 1'b1;
               end
            end
            default: st_q <= CAP_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/trig_burst_capture.sv
module trig_burst_capture #(
   parameter int unsigned LANES         = 4,
   parameter int unsigned SAMP_W        = 32,
   parameter int unsigned FRAME_SAMPLES = 512,
   parameter int unsigned MAX_FRAMES    = 1024,
   localparam int unsigned DATA_W       = LANES * SAMP_W,
   localparam int unsigned BEATS        = FRAME_SAMPLES / LANES,
   localparam int unsigned FCNT_W       = $clog2(MAX_FRAMES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic [FCNT_W-1:0] nframes_i,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic [DATA_W-1:0] m_tdata,
   output logic              m_tvalid,
   input  logic              m_tready,
   output logic              m_tlast,
   output logic              busy_o,
   output logic              done_o,
   output logic              ovf_o
);
   generate
      if (FRAME_SAMPLES % LANES != 0) begin : g_bad_lanes
         $error("frame length must be a multiple of the lane count");
      end
      if (BEATS < 2) begin : g_bad_beats
         $error("a frame must span at least two beats");
      end
      if (MAX_FRAMES < 1) begin : g_bad_frames
         $error("at least one frame per window is required");
      end
   endgenerate

   logic start, take, drop, beat_last, frame_final, finish;

   assign start    = trig_i && !busy_o;
   assign m_tvalid = busy_o && in_valid;
   assign m_tdata  = in_data;
   assign take     = m_tvalid && m_tready;
   assign drop     = m_tvalid && !m_tready;
   assign m_tlast  = m_tvalid && beat_last;
   assign finish   = take && beat_last && frame_final;

   cap_beat_ctr #(.BEATS(BEATS)) u_beat (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (start),
      .adv    (take),
      .last_o (beat_last)
   );

   cap_frame_ctr #(.CW(FCNT_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .nframes_i (nframes_i),
      .adv       (take && beat_last),
      .final_o   (frame_final)
   );

   cap_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .finish (finish),
      .drop   (drop),
      .busy_o (busy_o),
      .done_o (done_o),
      .ovf_o  (ovf_o)
   );
endmodule

// File: rtl/cap_chk.sv
module cap_chk (
   input logic clk,
   input logic rst_n,
   input logic trig_i,
   input logic in_valid,
   input logic m_tready,
   input logic m_tvalid,
   input logic m_tlast,
   input logic busy_o,
   input logic done_o,
   input logic ovf_o
);
   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> busy_o);

   // R3
   last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_tlast |-> m_tvalid);

   // R1
   start_by_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(trig_i));

   // R4
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   // R4
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && in_valid && !m_tready) |=> ovf_o);

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !(trig_i && !busy_o)) |=> ovf_o);

   // R7
   busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !m_tlast) |=> busy_o);
endmodule

bind trig_burst_capture cap_chk u_chk (.*);

// File: tb/trig_burst_capture_bench.sv
module trig_burst_capture_bench;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         trig_i;
   logic [10:0]  nframes_i;
   logic         in_valid;
   logic [127:0] in_data;
   logic [127:0] m_tdata;
   logic         m_tvalid, m_tready, m_tlast, busy_o, done_o, ovf_o;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #2 clk = ~clk;

   trig_burst_capture u_trig_burst_capture (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .nframes_i(nframes_i),
      .in_valid(in_valid), .in_data(in_data), .m_tdata(m_tdata),
      .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
      .busy_o(busy_o), .done_o(done_o), .ovf_o(ovf_o)
   );

   // upstream source: {frame index, sample index} per lane
   int up_cnt = 0;
   always_comb begin
      for (int k = 0; k < 4; k++) begin
         in_data[32*k +: 16]    = 16'((up_cnt * 4 + k) % 512);
         in_data[32*k+16 +: 16] = 16'((up_cnt * 4 + k) / 512);
      end
   end

   // behavioural reference
   bit m_act, m_done, m_ovf;
   int m_beat, m_frame, m_nf;
   int seen_beats, seen_lasts;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (in_valid) up_cnt <= up_cnt + 1;
      if (m_tvalid && m_tready) seen_beats <= seen_beats + 1;
      if (m_tvalid && m_tready && m_tlast) seen_lasts <= seen_lasts + 1;
      if (!rst_n) begin
         m_act = 0; m_done = 0; m_ovf = 0; m_beat = 0; m_frame = 0; m_nf = 1;
      end else begin
         m_done = 0;
         if (!m_act && trig_i) begin
            m_act = 1; m_beat = 0; m_frame = 0; m_ovf = 0;
            m_nf = (nframes_i == 0) ? 1 : int'(nframes_i);
         end else if (m_act && in_valid) begin
            if (!m_tready) m_ovf = 1;
            else if (m_beat == 127) begin
               m_beat = 0;
               if (m_frame == m_nf - 1) begin m_act = 0; m_done = 1; end
               else m_frame++;
            end else m_beat++;
         end
      end
   end

   task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h cyc=%0d", tag, act, exp, cyc);
      end
   endtask

   int vmode = 0, rmode = 0;

   task automatic step(bit trig, int nf);
      @(negedge clk);
      trig_i    = trig;
      nframes_i = 11'(nf);
      in_valid  = (vmode == 0) ? 1'b1 : ((cyc % 5) != 2);
      m_tready  = (rmode == 0) ? 1'b1 : ((cyc % 7) != 3);
      #1;
      chk("R2 tvalid", 128'(m_tvalid), 128'(m_act && in_valid));
      if (m_act && in_valid) chk("R2 tdata", m_tdata, in_data);
      chk("R3 tlast", 128'(m_tlast), 128'(m_act && in_valid && m_beat == 127));
      chk("R1 busy", 128'(busy_o), 128'(m_act));
      chk("R4 done", 128'(done_o), 128'(m_done));
      chk("R8 ovf", 128'(ovf_o), 128'(m_ovf));
   endtask

   task automatic burst(string tag, int nf, bit noise);
      int eff;
      eff = (nf == 0) ? 1 : nf;
      step(1'b0, nf);
      seen_beats = 0;
      seen_lasts = 0;
      step(1'b1, nf);
      for (int i = 0; i < 140000; i++) begin
         step(noise && (i % 50 == 7), noise ? 7 : nf);
         if (m_done) break;
      end
      chk({tag, " beats"}, 128'(seen_beats), 128'(eff * 128));
      chk({tag, " frames"}, 128'(seen_lasts), 128'(eff));
   endtask

   initial begin
      #750000;
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; trig_i = 1'b0; nframes_i = '0; in_valid = 1'b1; m_tready = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      // R11
      chk("R11 busy", 128'(busy_o), 128'(0));
      chk("R11 done", 128'(done_o), 128'(0));
      chk("R11 ovf", 128'(ovf_o), 128'(0));
      chk("R11 tvalid", 128'(m_tvalid), 128'(0));
      @(negedge clk); rst_n = 1'b1;
      for (int i = 0; i < 37; i++) step(1'b0, 2);   // unaligned upstream offset
      burst("R1 R3 R4 nf2", 2, 1'b0);
      burst("R6 nf0", 0, 1'b0);
      burst("R5 R7 nf3", 3, 1'b1);
      vmode = 1;
      burst("R9 gaps", 2, 1'b0);
      rmode = 1;
      burst("R8 drops", 2, 1'b0);
      rmode = 0; vmode = 0;
      for (int i = 0; i < 5; i++) step(1'b0, 1);
      chk("R8 sticky after window", 128'(ovf_o), 128'(1));
      step(1'b1, 1);
      step(1'b0, 1);
      chk("R8 cleared by trigger", 128'(ovf_o), 128'(0));
      for (int i = 0; i < 200; i++) step(1'b0, 1);
      burst("R10 nf1024", 1024, 1'b0);
      for (int i = 0; i < 4; i++) step(1'b0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule